// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the per-bus register front end of an I2C master. Software programs a small register file and then writes a command word. The block turns each command write into a short series of byte-level requests to a separate bit-timing engine: an address phase with start, a byte transmit, a byte receive, and a stop. It then condenses the outcome into interrupt status bits and drives a level interrupt.

The engine side is a request/done handshake. The block holds `eng_req` together with an operation code until the engine pulses `eng_done`. With that pulse the engine returns an acknowledge flag and, for a receive, the received byte. The engine also reports whether the bus is currently owned through `bus_busy`.

Registers are selected by a 3-bit word index:

| Index | Register |
|---|---|
| 0 | control |
| 1 | interrupt enable |
| 2 | interrupt status |
| 3 | byte buffer |
| 4 | command |

Reads of any other index return zero.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Reset clears the control, enable, status, command and buffer registers and holds `irq` low. If the engine reports the bus busy just after reset, one stop request (op 3) is issued to release it, and no status is produced.
- R2: A command with bit0 (start) set requests op 0 and passes buffer bits [7:0] to the engine: bits [7:1] are the target address and bit 0 is the read flag. A NAK sets status bit1, and an ACK sets status bit0.
- R3: Within one command write, only the first of start (bit0), master transmit (bit1) and master receive (bit3) is carried out, in that order. Bit2 is never acted on. Stop (bit5) or receive-last (bit4) is handled after that primary operation.
- R4: A transmit (op 1) sends buffer bits [7:0]. An ACK sets status bit0. A NAK sets bits 1 and 5 and is followed by a stop request (op 3) that releases the bus.
- R5: A receive (op 2) places the returned byte in buffer bits [15:8], clears bits [7:0] and sets status bit2. A host write to the buffer (index 3) keeps only data bits [7:0] and clears bits [15:8].
- R6: When stop or receive-last is set, an idle bus sets status bit5 and issues no request. Otherwise a stop request (op 3) is issued, and its completion sets status bit4.
- R7: An accepted command write clears interrupt status in the next cycle. Command reads (index 4) return the accepted bits [5:0] while the command runs; those bits read zero once it completes.
- R8: Command writes are ignored unless control bit0 or bit1 is set. Control writes (index 0) keep only the bits of 0x0071C3FF.
- R9: At completion, status is the gathered result ANDed with the 15-bit enable register (index 1). Writing ones to status (index 2) clears those bits. `irq` is high whenever any status bit is set.
- R10: While a command runs, further command writes are ignored. `eng_req` and `eng_op` stay stable until `eng_done`.
- R11: Command reads (index 4) return the engine's bus-busy flag in bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt, OR of status bits |
| eng_req | output | 1 | Engine request, held until done |
| eng_op | output | 2 | Engine operation: 0 start, 1 transmit, 2 receive, 3 stop |
| eng_wdata | output | 8 | Address byte or transmit byte |
| eng_done | input | 1 | Engine completion pulse |
| eng_nak | input | 1 | Not acknowledged, valid with done |
| eng_rdata | input | 8 | Received byte, valid with done |
| bus_busy | input | 1 | Bus currently owned |

## Verification
Status clearing after an accepted command write is due one edge after the write, so the bench reads status at the falling edge that follows it. The final status, buffer contents and cleared command bits arrive only after the engine's last done pulse plus one decision cycle. The bench therefore polls the command register, at falling edges, until its low bits drop to zero, and then compares every register against values predicted from its own responder log. Engine requests are counted by the responder when it completes them, which lets priority, hold-off and ignored writes be checked as an exact number of operations.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 15;
  localparam int CMD_W  = 6;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {OP_START = 2'd0, OP_TX = 2'd1, OP_RX = 2'd2, OP_STOP = 2'd3} eng_op_t;

  localparam logic [REG_AW-1:0] IX_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] IX_IEN  = 3'd1;
  localparam logic [REG_AW-1:0] IX_STAT = 3'd2;
  localparam logic [REG_AW-1:0] IX_BUF  = 3'd3;
  localparam logic [REG_AW-1:0] IX_CMD  = 3'd4;

  localparam int CB_START = 0;
  localparam int CB_MTX   = 1;
  localparam int CB_MRX   = 3;
  localparam int CB_LAST  = 4;
  localparam int CB_STOP  = 5;

  localparam int SB_ACK   = 0;
  localparam int SB_NAK   = 1;
  localparam int SB_RXD   = 2;
  localparam int SB_NSTOP = 4;
  localparam int SB_ABN   = 5;

  localparam logic [31:0] CTRL_KEEP = 32'h0071_C3FF;

  typedef struct packed {
    logic    valid;
    eng_op_t op;
  } prim_t;

  // First of start / transmit / receive, in that order.
  function automatic prim_t pick_primary(input logic [CMD_W-1:0] c);
    prim_t p;
    p.valid = 1'b1;
    if (c[CB_START])      p.op = OP_START;
    else if (c[CB_MTX])   p.op = OP_TX;
    else if (c[CB_MRX])   p.op = OP_RX;
    else begin
      p.valid = 1'b0;
      p.op    = OP_STOP;
    end
    return p;
  endfunction

  function automatic logic wants_stop(input logic [CMD_W-1:0] c);
    return c[CB_STOP] | c[CB_LAST];
  endfunction

  function automatic logic [STAT_W-1:0] stat_bit(input int pos);
    logic [STAT_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [BUS_W-1:0]     reg_wdata,
  input  logic                 cmd_accept,
  input  logic                 fin_vld,
  input  logic [STAT_W-1:0]    fin_stat,
  input  logic                 rx_vld,
  input  logic [DATA_W-1:0]    rx_byte,
  output logic [BUS_W-1:0]     ctrl_q,
  output logic [STAT_W-1:0]    ien_q,
  output logic [STAT_W-1:0]    stat_q,
  output logic [2*DATA_W-1:0]  buf_q,
  output logic                 irq
);
  logic wr_ctrl, wr_ien, wr_stat, wr_buf;

  assign wr_ctrl = reg_wr && (reg_addr == IX_CTRL);
  assign wr_ien  = reg_wr && (reg_addr == IX_IEN);
  assign wr_stat = reg_wr && (reg_addr == IX_STAT);
  assign wr_buf  = reg_wr && (reg_addr == IX_BUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      stat_q <= '0;
      buf_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP[BUS_W-1:0];
      if (wr_ien)  ien_q  <= reg_wdata[STAT_W-1:0];
      if (fin_vld)         stat_q <= fin_stat & ien_q;
      else if (cmd_accept) stat_q <= '0;
      else if (wr_stat)    stat_q <= stat_q & ~reg_wdata[STAT_W-1:0];
      if (rx_vld)      buf_q <= {rx_byte, {DATA_W{1'b0}}};
      else if (wr_buf) buf_q <= {{DATA_W{1'b0}}, reg_wdata[DATA_W-1:0]};
    end
  end

  assign irq = |stat_q;
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_wdata,
  input  logic                enabled,
  input  logic [DATA_W-1:0]   buf_lo,
  input  logic                bus_busy,
  output logic                eng_req,
  output eng_op_t             eng_op,
  output logic [DATA_W-1:0]   eng_wdata,
  input  logic                eng_done,
  input  logic                eng_nak,
  input  logic [DATA_W-1:0]   eng_rdata,
  output logic [CMD_W-1:0]    cmd_bits,
  output logic                cmd_accept,
  output logic                fin_vld,
  output logic [STAT_W-1:0]   fin_stat,
  output logic                rx_vld,
  output logic [DATA_W-1:0]   rx_byte
);
  typedef enum logic [2:0] {S_INIT, S_IDLE, S_PRIM, S_REL, S_CHK, S_STOP} st_t;

  st_t               st;
  eng_op_t           op_q;
  logic [STAT_W-1:0] acc;
  prim_t             prim;

  assign prim       = pick_primary(cmd_wdata);
  assign cmd_accept = (st == S_IDLE) && cmd_wr && enabled;
  assign eng_req    = (st == S_PRIM) || (st == S_REL) || (st == S_STOP);
  assign eng_op     = (st == S_PRIM) ? op_q : OP_STOP;
  assign eng_wdata  = buf_lo;
  assign rx_vld     = (st == S_PRIM) && eng_done && (op_q == OP_RX);
  assign rx_byte    = eng_rdata;

  always_comb begin
    fin_vld  = 1'b0;
    fin_stat = acc;
    if (st == S_CHK) begin
      if (!wants_stop(cmd_bits)) begin
        fin_vld = 1'b1;
      end else if (!bus_busy) begin
        fin_vld  = 1'b1;
        fin_stat = acc | stat_bit(SB_ABN);
      end
    end else if (st == S_STOP && eng_done) begin
      fin_vld  = 1'b1;
      fin_stat = acc | stat_bit(SB_NSTOP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_INIT;
      op_q     <= OP_STOP;
      acc      <= '0;
      cmd_bits <= '0;
    end else begin
      unique case (st)
        S_INIT: st <= bus_busy ? S_REL : S_IDLE;
        S_IDLE: begin
          if (cmd_accept) begin
            cmd_bits <= cmd_wdata;
            acc      <= '0;
            op_q     <= prim.op;
            st       <= prim.valid ? S_PRIM : S_CHK;
          end
        end
        S_PRIM: begin
          if (eng_done) begin
            st <= S_CHK;
            unique case (op_q)
              OP_START: acc <= acc | stat_bit(eng_nak ? SB_NAK : SB_ACK);
              OP_TX: begin
                if (eng_nak) begin
                  acc <= acc | stat_bit(SB_NAK) | stat_bit(SB_ABN);
                  st  <= S_REL;
                end else begin
                  acc <= acc | stat_bit(SB_ACK);
                end
              end
              OP_RX:   acc <= acc | stat_bit(SB_RXD);
              default: acc <= acc;
            endcase
          end
        end
        S_REL:  if (eng_done) st <= S_CHK;
        S_CHK: begin
          if (fin_vld) begin
            st       <= S_IDLE;
            cmd_bits <= '0;
          end else begin
            st <= S_STOP;
          end
        end
        S_STOP: begin
          if (eng_done) begin
            st       <= S_IDLE;
            cmd_bits <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int BUSY_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wdata,
  input  logic              eng_done,
  input  logic              eng_nak,
  input  logic [7:0]        eng_rdata,
  input  logic              bus_busy
);
  localparam int BUF_W = 2 * DATA_W;

  logic [BUS_W-1:0]  ctrl_q;
  logic [STAT_W-1:0] ien_q, stat_q, fin_stat;
  logic [BUF_W-1:0]  buf_q;
  logic [CMD_W-1:0]  cmd_bits;
  logic              cmd_accept, fin_vld, rx_vld, enabled, cmd_wr;
  logic [DATA_W-1:0] rx_byte;
  eng_op_t           op_e;

  assign enabled = ctrl_q[0] | ctrl_q[1];
  assign cmd_wr  = reg_wr && (reg_addr == IX_CMD);
  assign eng_op  = op_e;

  i2cs_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cmd_accept(cmd_accept), .fin_vld(fin_vld),
    .fin_stat(fin_stat), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .ctrl_q(ctrl_q), .ien_q(ien_q), .stat_q(stat_q), .buf_q(buf_q), .irq(irq)
  );

  i2cs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(reg_wdata[CMD_W-1:0]),
    .enabled(enabled), .buf_lo(buf_q[DATA_W-1:0]), .bus_busy(bus_busy),
    .eng_req(eng_req), .eng_op(op_e), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_nak(eng_nak), .eng_rdata(eng_rdata),
    .cmd_bits(cmd_bits), .cmd_accept(cmd_accept), .fin_vld(fin_vld),
    .fin_stat(fin_stat), .rx_vld(rx_vld), .rx_byte(rx_byte)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      IX_CTRL: reg_rdata = ctrl_q;
      IX_IEN:  reg_rdata[STAT_W-1:0] = ien_q;
      IX_STAT: reg_rdata[STAT_W-1:0] = stat_q;
      IX_BUF:  reg_rdata[BUF_W-1:0]  = buf_q;
      IX_CMD: begin
        reg_rdata[CMD_W-1:0] = cmd_bits;
        reg_rdata[BUSY_BIT]  = bus_busy;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_req,
  input logic [1:0]  eng_op,
  input logic        eng_done,
  input logic        cmd_accept,
  input logic        fin_vld,
  input logic [14:0] stat_q,
  input logic [14:0] ien_q,
  input logic [5:0]  cmd_bits
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op)));

  assert_no_req_at_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> !eng_req);

  assert_stat_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (stat_q == '0));

  assert_cmd_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_vld |=> (cmd_bits == '0));

  assert_stat_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_vld |=> ((stat_q & ~$past(ien_q)) == '0));

  assert_accept_fin_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_accept, fin_vld}));
endmodule

bind i2c_cmd_seq i2cs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_op(eng_op),
  .eng_done(eng_done), .cmd_accept(cmd_accept), .fin_vld(fin_vld),
  .stat_q(stat_q), .ien_q(ien_q), .cmd_bits(cmd_bits)
);

// File: tb/tb_i2c_cmd_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmd_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq, eng_req;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wdata;
  logic        eng_done = 0, eng_nak = 0, bus_busy = 0;
  logic [7:0]  eng_rdata = 0;

  int n_chk = 0, n_bad = 0, cyc = 0, cnt = 0, ops = 0, stops = 0;
  logic [7:0] rxq[$];
  logic [7:0] sent[$];

  always #2 clk = ~clk;

  i2c_cmd_seq dut (.*);

  // Behavioural responder: target 7'h50 answers, byte 8'hEE is refused.
  always @(negedge clk) begin
    cyc++;
    if (eng_done) begin
      eng_done <= 0; eng_nak <= 0; cnt = 0;
    end else if (eng_req) begin
      cnt++;
      if (cnt == 3) begin
        ops++;
        eng_done <= 1;
        case (eng_op)
          2'd0: begin eng_nak <= (eng_wdata[7:1] != 7'h50); bus_busy <= 1; end
          2'd1: begin eng_nak <= (eng_wdata == 8'hEE); sent.push_back(eng_wdata); end
          2'd2: begin eng_nak <= 0; eng_rdata <= (rxq.size() > 0) ? rxq.pop_front() : 8'hFF; end
          default: begin eng_nak <= 0; bus_busy <= 0; stops++; end
        endcase
      end
    end
    if (cyc > 50000) begin
      n_bad++; $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_cmd();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(3'd4, v);
      if (v[5:0] == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [31:0] c);
    wr(3'd4, c); wait_cmd();
  endtask

  logic [31:0] v;
  int o0, s0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 ien", v, 0);
    rd(3'd2, v); chk("R1 stat", v, 0);
    rd(3'd3, v); chk("R1 buf", v, 0);
    rd(3'd4, v); chk("R1 cmd", v, 0);
    chk("R1 irq", irq, 0);
    // R8 disabled: command ignored
    wr(3'd3, 32'hA0);
    o0 = ops; run(32'h1); repeat (6) @(negedge clk);
    chk("R8 disabled no op", ops - o0, 0);
    rd(3'd4, v); chk("R8 disabled cmd", v, 0);
    // R8 control mask
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R8 ctrl mask", v, 32'h0071C3FF);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'hFFFF);
    rd(3'd1, v); chk("R9 ien width", v, 32'h7FFF);
    // R2 start ack, R11 busy flag, R7 running bits
    wr(3'd3, 32'hA0);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R7 cmd bits while running", v[5:0], 6'h01);
    rd(3'd2, v); chk("R7 stat cleared", v, 0);
    wait_cmd();
    rd(3'd2, v); chk("R2 start ack", v, 32'h1);
    chk("R9 irq set", irq, 1);
    rd(3'd4, v); chk("R11 busy bit", v, 32'h0001_0000);
    // R4 transmit ack, R3 priority tx over rx
    wr(3'd3, 32'h1_12); o0 = ops;
    run(32'h0A);
    rd(3'd2, v); chk("R4 tx ack", v, 32'h1);
    chk("R3 tx beats rx", ops - o0, 1);
    chk("R4 byte sent", sent[$], 8'h12);
    // R4 transmit nak: abnormal plus release
    wr(3'd3, 32'hEE); s0 = stops;
    run(32'h2);
    rd(3'd2, v); chk("R4 tx nak", v, 32'h22);
    chk("R4 release stop", stops - s0, 1);
    rd(3'd4, v); chk("R4 bus released", v, 0);
    // R6 stop with idle bus
    o0 = ops; run(32'h20);
    rd(3'd2, v); chk("R6 stop idle abnormal", v, 32'h20);
    chk("R6 no request", ops - o0, 0);
    // R3 start beats tx, then stop handled after
    wr(3'd3, 32'hA1); rxq.push_back(8'h5C); rxq.push_back(8'h3D);
    o0 = ops; run(32'h23);
    rd(3'd2, v); chk("R3 start then stop", v, 32'h11);
    chk("R3 two ops", ops - o0, 2);
    // R5 receive
    wr(3'd3, 32'hA1); run(32'h1);
    run(32'h8);
    rd(3'd2, v); chk("R5 rx done", v, 32'h4);
    rd(3'd3, v); chk("R5 rx byte", v, 32'h5C00);
    // R6 receive-last with busy bus
    run(32'h18);
    rd(3'd2, v); chk("R6 rx last stop", v, 32'h14);
    rd(3'd3, v); chk("R5 second rx", v, 32'h3D00);
    // R5 buffer write
    wr(3'd3, 32'hFFFF_F1FF); rd(3'd3, v); chk("R5 buf write", v, 32'hFF);
    // R9 write-one-to-clear
    wr(3'd2, 32'h4); rd(3'd2, v); chk("R9 w1c", v, 32'h10);
    wr(3'd2, 32'h10); chk("R9 irq low", irq, 0);
    // R10 hold-off
    wr(3'd3, 32'hA0); o0 = ops;
    wr(3'd4, 32'h1); wr(3'd4, 32'h2);
    wait_cmd(); repeat (8) @(negedge clk);
    chk("R10 held-off write ignored", ops - o0, 1);
    rd(3'd2, v); chk("R10 status from first", v, 32'h1);
    // R3 bit2 alone is not acted on
    o0 = ops; run(32'h4); repeat (6) @(negedge clk);
    chk("R3 slave tx bit ignored", ops - o0, 0);
    // R6 normal stop on busy bus
    run(32'h20);
    rd(3'd2, v); chk("R6 normal stop", v, 32'h10);
    // R2 start nak, R9 masking
    wr(3'd1, 32'h1); wr(3'd3, 32'h66);
    run(32'h1);
    rd(3'd2, v); chk("R9 nak masked", v, 0);
    chk("R2 nak irq masked", irq, 0);
    wr(3'd1, 32'h7FFF); run(32'h1);
    rd(3'd2, v); chk("R2 start nak", v, 32'h2);
    // R8 disabled keeps status untouched
    wr(3'd0, 32'h0); o0 = ops; run(32'h20);
    rd(3'd2, v); chk("R8 disabled status kept", v, 32'h2);
    chk("R8 disabled no request", ops - o0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule